// File: doc/BRIEF.md
# Programmable Serial Flash Sequence Engine

This block drives a serial flash device over a chip select, a serial clock and up to four bidirectional data lanes. The transactions are not hard-wired. Each one is a short program of 16-bit instructions stored in a table of 64 32-bit words. The table holds 16 programs of four words each, and every word packs two instructions. Software fills the table through a small register port, which is guarded by a key-and-lock scheme. It loads an address register and then starts a program by writing a program number and a byte count to the command register.

While a program runs, the engine reads one instruction at a time. Each instruction sends an opcode byte, shifts out an address, idles for dummy clocks, receives data, sends data, or finishes. Received bytes leave on a byte-wide valid/ready stream. Bytes to transmit arrive on a second byte-wide valid/ready stream. When either stream is not ready, the engine holds the serial clock low and waits. A busy output stays high for the whole transaction.

Top module: `flash_seq_engine`

## Requirements
- R1: Register port addresses (`regAddr`): 0 is the command register, 1 the address register, 2 the key register, 3 the lock control register, and 64+i is table word i. A command write while idle starts a transaction. It takes the program number from bits [27:24] and the byte count from bits [15:0]. `busy` is high from the next cycle until the end, and `csN` is low exactly while `busy` is high.
- R2: In each table word, instruction 0 sits in bits [15:0] and is executed before instruction 1 in bits [31:16]. Program p starts at word 4·p. Within an instruction, bits [15:10] are the opcode, bits [9:8] are the lane code and bits [7:0] are the operand.
- R3: Opcode values: 0 finishes, 1 sends a command byte, 2 sends an address, 3 inserts dummy clocks, 7 reads, 8 writes, and 9 finishes as well. Every other value is skipped without any serial clock.
- R4: Lane code 0 uses io[0], code 1 uses io[1:0] and code 2 uses io[3:0], with io[3] (or io[1]) as the most significant lane. Code 3 behaves like code 0.
- R5: A command instruction shifts out its 8-bit operand, most significant bits first, in 8/lanes clocks. Output enables are set on exactly the lanes in use.
- R6: An address instruction shifts out the low N bits of the address register, most significant first, in N/lanes clocks. N is the operand, clamped to 32.
- R7: A dummy instruction gives operand-many clocks with every output enable low.
- R8: A read instruction receives the command's byte count in bytes. A one-lane read samples io[1]. Wider reads place earlier lane groups in the higher bits. Each byte is held on `rxData`/`rxValid` until `rxReady`, and the serial clock stays low during the wait. A count of 0 skips the read.
- R9: A write instruction takes the command's byte count in bytes from `txData`/`txValid` (it accepts a byte when `txReady` and `txValid` are both high). It shifts each byte out most significant bits first on the selected lanes and waits with the clock low while `txValid` is low.
- R10: A transaction ends at opcode 0 or 9, or after the eighth instruction of the program has run. At the end `csN` rises and `busy` falls.
- R11: A command write while `busy` is high is ignored.
- R12: After reset the table is locked and all zero. Writing 0x5AF05AF0 to the key register arms the lock. The next write to lock control then unlocks (value 2) or locks (value 1), and any lock control write disarms. Table writes while locked change nothing.
- R13: `sclk` idles low. Each serial clock lasts two system cycles: low, then high. Each instruction costs one extra fetch cycle. Outputs change only while `sclk` is low, and inputs are sampled as `sclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Register / table word address |
| regWdata | input | 32 | Register write data |
| busy | output | 1 | Transaction in progress |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| ioOut | output | 4 | Lane output values |
| ioOe | output | 4 | Lane output enables |
| ioIn | input | 4 | Lane input values |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte available |
| txReady | output | 1 | Engine takes the transmit byte |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Received byte available |
| rxReady | input | 1 | Consumer takes the received byte |

## Verification
Faults in this block show up directly at the pins. A wrong instruction pointer or table index changes the opcode bits or the clock count seen in the first beats of the transaction. A wrong beat or byte counter changes the number of rising edges on `sclk` and the moment `busy` falls, which is visible within one instruction. Lane mapping and bit-order faults corrupt the very first nibble compared on the serial lines or the first byte on the receive stream. Lock-state faults appear on the next run of a program that software tried to overwrite while the table was locked.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_ADDR  = 6'd2;
  localparam logic [5:0] OP_DUMMY = 6'd3;
  localparam logic [5:0] OP_READ  = 6'd7;
  localparam logic [5:0] OP_WRITE = 6'd8;
  localparam logic [5:0] OP_JMPCS = 6'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOW, S_HIGH, S_TXW, S_RXH
  } seqState_t;

  typedef enum logic [1:0] {
    K_OUT, K_DUMMY, K_READ, K_WRITE
  } chunkKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic        load;
    logic [31:0] loadVal;
    logic        shift;
    logic        capture;
    logic        drive;
    logic [1:0]  laneSel;   // 0: one lane, 1: two lanes, 2: four lanes
  } dpCtl_t;

  function automatic logic [1:0] laneLog(input logic [1:0] sel);
    return (sel == 2'd2) ? 2'd2 : ((sel == 2'd1) ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [7:0] byteBeats(input logic [1:0] sel);
    return 8'(8 >> laneLog(sel));
  endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int          LEN_W         = 16,
  parameter int          NUM_SEQ       = 16,
  parameter int          WORDS_PER_SEQ = 4,
  parameter logic [31:0] UNLOCK_KEY    = 32'h5AF0_5AF0
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      regWe,
  input  logic [$clog2(NUM_SEQ*WORDS_PER_SEQ):0]    regAddr,
  input  logic [31:0]                               regWdata,
  input  logic                                      txValid,
  input  logic [7:0]                                txData,
  input  logic                                      rxReady,
  output logic                                      txReady,
  output logic                                      rxValid,
  output logic                                      busy,
  output logic                                      csN,
  output logic                                      sclk,
  output dpCtl_t                                    dpCtl
);

  localparam int TBL_DEPTH = NUM_SEQ * WORDS_PER_SEQ;
  localparam int IDX_W     = $clog2(TBL_DEPTH);
  localparam int SEQ_W     = $clog2(NUM_SEQ);
  localparam int MAX_INSTR = WORDS_PER_SEQ * 2;
  localparam int IP_W      = $clog2(MAX_INSTR);
  localparam int REG_AW    = IDX_W + 1;

  logic [31:0]      tbl [TBL_DEPTH];
  logic             unlocked, keyOk;
  logic [SEQ_W-1:0] seqId;
  logic [LEN_W-1:0] lenReg, byteCnt;
  logic [31:0]      addrReg;
  logic [IP_W-1:0]  ip;
  seqState_t        state;
  chunkKind_t       kind;
  logic [1:0]       laneSel;
  logic [7:0]       beatCnt;
  logic             sclkQ;

  logic cmdWe, addrWe, keyWe, lockWe, tblWe;
  assign cmdWe  = regWe && (regAddr == REG_AW'(0));
  assign addrWe = regWe && (regAddr == REG_AW'(1));
  assign keyWe  = regWe && (regAddr == REG_AW'(2));
  assign lockWe = regWe && (regAddr == REG_AW'(3));
  assign tblWe  = regWe && regAddr[IDX_W] && unlocked;

  // instruction fetch and decode
  logic [31:0] curWord;
  logic [15:0] curInstr;
  logic [5:0]  fOp;
  logic [1:0]  fPad;
  logic [7:0]  fOpnd;
  logic [5:0]  fAddrBits;
  logic [7:0]  addrBeats;
  logic [31:0] addrShifted;
  logic        lastInstr;
  seqState_t   advState;

  always_comb begin
    curWord     = tbl[{seqId, ip[IP_W-1:1]}];
    curInstr    = ip[0] ? curWord[31:16] : curWord[15:0];
    fOp         = curInstr[15:10];
    fPad        = (curInstr[9:8] == 2'd3) ? 2'd0 : curInstr[9:8];
    fOpnd       = curInstr[7:0];
    fAddrBits   = (fOpnd > 8'd32) ? 6'd32 : fOpnd[5:0];
    addrBeats   = 8'(fAddrBits >> laneLog(fPad));
    addrShifted = addrReg << (6'd32 - fAddrBits);
    lastInstr   = (ip == IP_W'(MAX_INSTR - 1));
    advState    = lastInstr ? S_IDLE : S_FETCH;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
      unlocked <= 1'b0;
      keyOk    <= 1'b0;
      seqId    <= '0;
      lenReg   <= '0;
      byteCnt  <= '0;
      addrReg  <= '0;
      ip       <= '0;
      state    <= S_IDLE;
      kind     <= K_OUT;
      laneSel  <= 2'd0;
      beatCnt  <= '0;
      sclkQ    <= 1'b0;
    end else begin
      if (tblWe) tbl[regAddr[IDX_W-1:0]] <= regWdata;
      if (keyWe) keyOk <= (regWdata == UNLOCK_KEY);
      if (lockWe) begin
        keyOk <= 1'b0;
        if (keyOk && regWdata == 32'd2) unlocked <= 1'b1;
        else if (keyOk && regWdata == 32'd1) unlocked <= 1'b0;
      end
      if (addrWe) addrReg <= regWdata;
      sclkQ <= (state == S_LOW);

      unique case (state)
        S_IDLE: if (cmdWe) begin
          seqId  <= regWdata[27:24];
          lenReg <= regWdata[LEN_W-1:0];
          ip     <= '0;
          state  <= S_FETCH;
        end
        S_FETCH: begin
          laneSel <= fPad;
          unique case (fOp)
            OP_STOP, OP_JMPCS: state <= S_IDLE;
            OP_CMD: begin
              kind <= K_OUT; beatCnt <= byteBeats(fPad); state <= S_LOW;
            end
            OP_ADDR: if (addrBeats != 8'd0) begin
              kind <= K_OUT; beatCnt <= addrBeats; state <= S_LOW;
            end else begin
              ip <= ip + IP_W'(1); state <= advState;
            end
            OP_DUMMY: if (fOpnd != 8'd0) begin
              kind <= K_DUMMY; beatCnt <= fOpnd; state <= S_LOW;
            end else begin
              ip <= ip + IP_W'(1); state <= advState;
            end
            OP_READ: if (lenReg != '0) begin
              kind <= K_READ; byteCnt <= lenReg; beatCnt <= byteBeats(fPad); state <= S_LOW;
            end else begin
              ip <= ip + IP_W'(1); state <= advState;
            end
            OP_WRITE: if (lenReg != '0) begin
              kind <= K_WRITE; byteCnt <= lenReg; state <= S_TXW;
            end else begin
              ip <= ip + IP_W'(1); state <= advState;
            end
            default: begin
              ip <= ip + IP_W'(1); state <= advState;
            end
          endcase
        end
        S_LOW: state <= S_HIGH;
        S_HIGH: begin
          beatCnt <= beatCnt - 8'd1;
          if (beatCnt == 8'd1) begin
            if (kind == K_READ) state <= S_RXH;
            else if (kind == K_WRITE && byteCnt != LEN_W'(1)) begin
              byteCnt <= byteCnt - LEN_W'(1);
              state   <= S_TXW;
            end else begin
              ip <= ip + IP_W'(1); state <= advState;
            end
          end else state <= S_LOW;
        end
        S_RXH: if (rxReady) begin
          if (byteCnt == LEN_W'(1)) begin
            ip <= ip + IP_W'(1); state <= advState;
          end else begin
            byteCnt <= byteCnt - LEN_W'(1);
            beatCnt <= byteBeats(laneSel);
            state   <= S_LOW;
          end
        end
        S_TXW: if (txValid) begin
          beatCnt <= byteBeats(laneSel);
          state   <= S_LOW;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.load    = (state == S_FETCH && (fOp == OP_CMD || fOp == OP_ADDR))
                 || (state == S_TXW && txValid);
    dpCtl.loadVal = (state == S_TXW) ? {txData, 24'h0}
                  : ((fOp == OP_CMD) ? {fOpnd, 24'h0} : addrShifted);
    dpCtl.shift   = (state == S_HIGH) && (kind != K_READ);
    dpCtl.capture = (state == S_LOW) && (kind == K_READ);
    dpCtl.drive   = (state == S_LOW || state == S_HIGH) && (kind == K_OUT || kind == K_WRITE);
    dpCtl.laneSel = laneSel;
  end

  assign busy    = (state != S_IDLE);
  assign csN     = (state == S_IDLE);
  assign sclk    = sclkQ;
  assign txReady = (state == S_TXW);
  assign rxValid = (state == S_RXH);

  // R13: serial clock only pulses inside a transaction
  p_sclk_in_txn_r13: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);
  // R9: engine keeps offering until a byte arrives
  p_tx_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !txValid) |=> txReady);
  // R11: a transaction starts only from a command write
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdWe));
  // R12: unlock only after an armed lock-control write
  p_unlock_src_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(lockWe && keyOk));

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [LANES-1:0] ioIn,
  output logic [LANES-1:0] ioOut,
  output logic [LANES-1:0] ioOe,
  output logic [7:0]       rxByte
);

  logic [31:0] shReg;
  logic [7:0]  rxSh;
  logic [2:0]  width;

  always_comb begin
    unique case (ctl.laneSel)
      2'd1:    width = 3'd2;
      2'd2:    width = 3'd4;
      default: width = 3'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      rxSh  <= '0;
    end else begin
      if (ctl.load) shReg <= ctl.loadVal;
      else if (ctl.shift) shReg <= shReg << width;
      if (ctl.capture) begin
        unique case (ctl.laneSel)
          2'd1:    rxSh <= {rxSh[5:0], ioIn[1:0]};
          2'd2:    rxSh <= {rxSh[3:0], ioIn[3:0]};
          default: rxSh <= {rxSh[6:0], ioIn[1]};
        endcase
      end
    end
  end

  // per-lane output mapping: lane i carries bit (32 - width + i) of the shifter
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       inUse;
    logic [5:0] bitIdx;
    always_comb begin
      inUse    = (32'(i) < 32'(width));
      bitIdx   = 6'(32 - 32'(width) + i);
      ioOut[i] = inUse ? shReg[bitIdx[4:0]] : 1'b0;
      ioOe[i]  = inUse && ctl.drive;
    end
  end

  assign rxByte = rxSh;

  // R8: a received bit is never sampled in the same cycle the shifter is reloaded
  p_load_vs_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.capture));

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int          LEN_W         = 16,
  parameter int          NUM_SEQ       = 16,
  parameter int          WORDS_PER_SEQ = 4,
  parameter logic [31:0] UNLOCK_KEY    = 32'h5AF0_5AF0
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   regWe,
  input  logic [$clog2(NUM_SEQ*WORDS_PER_SEQ):0] regAddr,
  input  logic [31:0]                            regWdata,
  output logic                                   busy,
  output logic                                   csN,
  output logic                                   sclk,
  output logic [3:0]                             ioOut,
  output logic [3:0]                             ioOe,
  input  logic [3:0]                             ioIn,
  input  logic [7:0]                             txData,
  input  logic                                   txValid,
  output logic                                   txReady,
  output logic [7:0]                             rxData,
  output logic                                   rxValid,
  input  logic                                   rxReady
);

  dpCtl_t dpCtl;

  flash_seq_ctrl #(
    .LEN_W(LEN_W), .NUM_SEQ(NUM_SEQ), .WORDS_PER_SEQ(WORDS_PER_SEQ), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .txValid(txValid), .txData(txData), .rxReady(rxReady),
    .txReady(txReady), .rxValid(rxValid), .busy(busy), .csN(csN), .sclk(sclk),
    .dpCtl(dpCtl)
  );

  flash_seq_dp #(.LANES(4)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .rxByte(rxData)
  );

  // R8: an offered byte stays put until taken
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

endmodule

// File: tb/flash_seq_engine_bench.sv
module flash_seq_engine_bench;

  localparam logic [31:0] KEYV = 32'h5AF0_5AF0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic       busy, csN, sclk, txReady, rxValid;
  logic [3:0] ioOut, ioOe;
  logic [3:0] ioIn = '0;
  logic [7:0] txData = '0, rxData;
  logic       txValid = 1'b0, rxReady = 1'b0;

  always #10 clk = ~clk;

  flash_seq_engine u_flash_seq_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .csN(csN), .sclk(sclk), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [3:0] beatOut [512];
  logic [3:0] beatOe  [512];
  int  nBeats = 0, busyCyc = 0, csFalls = 0, cyc = 0;
  logic [7:0] expRx [$];
  logic [7:0] txQ [$];
  bit txPend = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int pad, input int opr);
    return {6'(op), 2'(pad), 8'(opr)};
  endfunction

  function automatic logic [3:0] fIn(input int k);
    return 4'((k * 7 + 2) ^ (k >> 3));
  endfunction

  // flash model, stream driver and scoreboard monitor, all away from the active edge
  always @(negedge clk) begin
    if (sclk) begin
      beatOut[nBeats] = ioOut & ioOe;
      beatOe[nBeats]  = ioOe;
      nBeats++;
    end
    if (busy) busyCyc++;
    ioIn = fIn(nBeats);
    if (txPend) void'(txQ.pop_front());
    txValid = (txQ.size() > 0) && (cyc % 3 != 0);
    txData  = txValid ? txQ[0] : 8'h00;
    txPend  = txValid && txReady;
    rxReady = (cyc % 4 != 1);
    if (rxValid && rxReady) begin
      if (expRx.size() == 0) check(0, "R8", "unexpected rx byte", rxData, 0);
      else begin
        logic [7:0] e;
        e = expRx.pop_front();
        check(rxData == e, "R8", "rx byte", rxData, e);
      end
    end
    cyc++;
  end

  always @(negedge csN) csFalls++;

  task automatic regWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input int seq, input int len, input int expBeats, input string req);
    nBeats = 0; busyCyc = 0;
    regWr(7'd0, (32'(seq) << 24) | 32'(len));
    check(busy == 1'b1 && csN == 1'b0, "R1", "busy after trigger", {busy, csN}, 2'b10);
    waitIdle();
    check(nBeats == expBeats, req, "serial clock count", nBeats, expBeats);
    check(csN == 1'b1 && sclk == 1'b0, "R10", "chip select released", {csN, sclk}, 2'b10);
  endtask

  task automatic expOut(input int start, input logic [31:0] val, input int nbits,
                        input int lanes, input string req);
    logic [3:0] eo;
    eo = (lanes == 4) ? 4'hF : ((lanes == 2) ? 4'h3 : 4'h1);
    for (int b = 0; b < nbits / lanes; b++) begin
      logic [3:0] chunk;
      chunk = 4'((val >> (nbits - (b + 1) * lanes)) & ((32'd1 << lanes) - 1));
      check(beatOut[start + b] == chunk && beatOe[start + b] == eo, req, "lane beat",
            {beatOe[start + b], beatOut[start + b]}, {eo, chunk});
    end
  endtask

  task automatic expQuiet(input int start, input int n, input string req);
    for (int b = 0; b < n; b++)
      check(beatOe[start + b] == 4'h0, req, "lanes released", beatOe[start + b], 0);
  endtask

  task automatic pushRead(input int start, input int nbytes, input int lanes);
    int k;
    k = start;
    for (int by = 0; by < nbytes; by++) begin
      logic [7:0] v;
      v = '0;
      for (int j = 0; j < 8 / lanes; j++) begin
        logic [3:0] f;
        f = fIn(k);
        if (lanes == 1) v = {v[6:0], f[1]};
        else if (lanes == 2) v = {v[5:0], f[1:0]};
        else v = {v[3:0], f};
        k++;
      end
      expRx.push_back(v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1, R13: idle state after reset
    check(csN == 1'b1 && busy == 1'b0 && sclk == 1'b0, "R1", "reset pins", {csN, busy, sclk}, 3'b100);
    check(rxValid == 1'b0 && txReady == 1'b0 && ioOe == 4'h0, "R13", "reset streams",
          {rxValid, txReady, ioOe}, 0);

    // R12: locked after reset, the table write is dropped and program 2 is all stop (R3)
    regWr(7'd64 + 7'd8, {16'h0, ins(1, 0, 8'hAB)});
    run(2, 0, 0, "R12");
    // R12: a wrong key leaves the table locked
    regWr(7'd2, 32'h1234_5678);
    regWr(7'd3, 32'd2);
    regWr(7'd64 + 7'd8, {16'h0, ins(1, 0, 8'hAB)});
    run(2, 0, 0, "R12");

    regWr(7'd2, KEYV);
    regWr(7'd3, 32'd2);
    // R2: programs at word 4*p, instruction 0 in the low half
    regWr(7'd64 + 7'd0,  {ins(2, 0, 24), ins(1, 0, 8'h6B)});
    regWr(7'd64 + 7'd1,  {ins(7, 2, 0), ins(3, 0, 8)});
    regWr(7'd64 + 7'd4,  {ins(2, 0, 32), ins(1, 0, 8'h02)});
    regWr(7'd64 + 7'd5,  {ins(0, 0, 0), ins(8, 1, 0)});
    regWr(7'd64 + 7'd12, {ins(7, 0, 0), ins(1, 0, 8'h05)});
    for (int w = 16; w < 20; w++) regWr(7'(64 + w), {ins(3, 0, 2), ins(3, 0, 2)});
    regWr(7'd64 + 7'd20, {ins(4, 0, 8'h55), ins(1, 2, 8'hEB)});
    regWr(7'd64 + 7'd21, {ins(9, 0, 0), ins(7, 2, 0)});
    regWr(7'd64 + 7'd24, {ins(0, 0, 0), ins(2, 2, 40)});
    regWr(7'd64 + 7'd28, {ins(0, 0, 0), ins(1, 3, 8'hC3)});

    // quad read: R5 command, R6 24-bit address, R7 dummy, R8 four-lane read
    regWr(7'd1, 32'h00A5_3C96);
    pushRead(40, 3, 4);
    run(0, 3, 46, "R8");
    expOut(0, 32'h6B, 8, 1, "R5");
    expOut(8, 32'hA53C96, 24, 1, "R6");
    expQuiet(32, 8, "R7");
    expQuiet(40, 6, "R8");
    check(expRx.size() == 0, "R8", "all rx bytes delivered", expRx.size(), 0);

    // program with 32-bit address and a two-lane write (R9, R4)
    regWr(7'd1, 32'hDEAD_BEEF);
    txQ.push_back(8'h5A); txQ.push_back(8'hC3);
    run(1, 2, 48, "R9");
    expOut(0, 32'h02, 8, 1, "R5");
    expOut(8, 32'hDEADBEEF, 32, 1, "R6");
    expOut(40, 32'h5A, 8, 2, "R9");
    expOut(44, 32'hC3, 8, 2, "R4");
    check(txQ.size() == 0, "R9", "tx bytes consumed", txQ.size(), 0);

    // one-lane read samples io[1] (R8), then a zero count skips the read
    pushRead(8, 1, 1);
    run(3, 1, 16, "R8");
    expOut(0, 32'h05, 8, 1, "R5");
    check(expRx.size() == 0, "R8", "single-lane byte delivered", expRx.size(), 0);
    run(3, 0, 8, "R8");

    // eight dummies without stop, plus a trigger while busy (R10, R11, R13)
    begin
      int c0;
      c0 = csFalls;
      nBeats = 0; busyCyc = 0;
      regWr(7'd0, 32'h0400_0000);
      regWr(7'd0, 32'h0000_0003);
      waitIdle();
      check(nBeats == 16, "R10", "ends after eighth instruction", nBeats, 16);
      check(csFalls - c0 == 1, "R11", "trigger while busy ignored", csFalls - c0, 1);
      check(expRx.size() == 0 && rxValid == 1'b0, "R11", "no read from ignored trigger", rxValid, 0);
      check(busyCyc == 40, "R13", "busy cycles for 8 x 2 clocks", busyCyc, 40);
    end

    // four-lane command, skipped mode opcode, zero-length read, jump ends (R3, R10)
    run(5, 0, 2, "R3");
    expOut(0, 32'hEB, 8, 4, "R4");

    // address operand above 32 clamps, four lanes (R6)
    run(6, 0, 8, "R6");
    expOut(0, 32'hDEADBEEF, 32, 4, "R6");

    // lane code 3 acts as one lane (R4)
    run(7, 0, 8, "R4");
    expOut(0, 32'hC3, 8, 1, "R4");

    // relock; the overwrite of program 3 must not land (R12)
    regWr(7'd2, KEYV);
    regWr(7'd3, 32'd1);
    regWr(7'd64 + 7'd12, {ins(0, 0, 0), ins(1, 0, 8'h9F)});
    run(3, 0, 8, "R12");
    expOut(0, 32'h05, 8, 1, "R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule